// File: doc/BRIEF.md
# Dual Non-Retriggerable One-Shot

This block is a pair of clocked monostable pulse generators. Each channel has two trigger inputs: one acts on its falling edge and one acts on its rising edge. Each also has an active-low clear and a pulse-length value. When a trigger is accepted, the channel drives its pulse output high for a number of clock cycles taken from its length input. The complementary output is low for that time. A down-counter inside the block times the pulse.

Both trigger inputs are asynchronous. Each one passes through a synchroniser chain before the edge detector sees it. Each trigger input is gated by the level of the other: the falling-edge input fires only while the rising-edge input is high, and the rising-edge input fires only while the falling-edge input is low. A running pulse cannot be extended or restarted. The clear input ends a pulse at once, with no wait for the clock. The two channels share only the clock and the power-on reset.

Top module: `oneshot_pair`

## Requirements
- R1: A falling edge on `trig_fall_i[i]` while `trig_rise_i[i]` is high starts a pulse. With the default two synchroniser stages, `pulse_o[i]` is first seen high after the third rising clock edge that follows the input change.
- R2: A rising edge on `trig_rise_i[i]` while `trig_fall_i[i]` is low starts a pulse, with the same latency as R1.
- R3: The block ignores a falling edge on `trig_fall_i[i]` while `trig_rise_i[i]` is low. It also ignores a rising edge on `trig_rise_i[i]` while `trig_fall_i[i]` is high.
- R4: `pulse_o[i]` stays high for exactly N clock cycles. N is the value of `width_i[i*CW +: CW]` at the moment the trigger is accepted, and a value of 0 counts as 1. Changing the width while a pulse runs has no effect on that pulse.
- R5: While a pulse runs, the block ignores any edge on either trigger input, whether or not the gating condition holds. The pulse ends at its original length, and no trigger is kept pending.
- R6: While `clr_n_i[i]` is low, `pulse_o[i]` is low and `pulse_n_o[i]` is high. Driving clear low forces these levels at once, without a clock edge, and ends any pulse in progress.
- R7: A trigger edge that arrives while `clr_n_i[i]` is low is ignored. Releasing the clear never starts a pulse by itself.
- R8: `pulse_n_o[i]` is always the inverse of `pulse_o[i]`.
- R9: While `rst_n` is low, every `pulse_o` is low. After `rst_n` is released, trigger levels that were already present do not start a pulse.
- R10: A trigger, clear or width change on one channel has no effect on the other channel's outputs. Both channels can run pulses at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the pulses |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| trig_fall_i | input | NCH | Falling-edge trigger, bit i for channel i |
| trig_rise_i | input | NCH | Rising-edge trigger, bit i for channel i |
| clr_n_i | input | NCH | Asynchronous clear, active low, bit i for channel i |
| width_i | input | NCH*CW | Pulse length in cycles, channel i at bits [i*CW +: CW] |
| pulse_o | output | NCH | Pulse output, high while a pulse runs |
| pulse_n_o | output | NCH | Inverse of pulse_o |

## Verification
The checker samples the pulse outputs only at rising clock edges. It assumes that every low period on a clear input spans at least one rising edge. A clear pulse that rose and fell between two edges would cut a pulse short without the checker seeing the clear, and the width property would fire wrongly. It also assumes that the block is reset before it runs. The bench changes every input just after a falling edge and holds each clear low for several cycles. It sets up each channel's idle trigger levels while that channel is held in clear, so that no stray edge starts a pulse before the measured one.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

   // State of a channel's pulse timer
   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_e;

   // Edge events produced by the gated detector
   typedef struct packed {
      logic fall_ev;
      logic rise_ev;
   } trig_ev_t;

endpackage

// File: rtl/os_sync.sv
// Multi-stage synchroniser for one asynchronous input bit.
module os_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/os_trig_gate.sv
// Edge detection with cross gating. The detector stays disarmed for
// a short time after reset, so levels present at release never fire.
module os_trig_gate
   import oneshot_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fall_s,
   input  logic rise_s,
   output logic fire
);

   localparam int ARM_CYC = SYNC_STAGES + 1;
   localparam int AW      = $clog2(ARM_CYC + 1);

   logic [AW-1:0] arm_cnt;
   logic          armed;
   logic          fall_q;
   logic          rise_q;
   trig_ev_t      ev;

   assign armed = (arm_cnt == AW'(ARM_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_cnt <= '0;
         fall_q  <= 1'b0;
         rise_q  <= 1'b0;
      end else begin
         fall_q <= fall_s;
         rise_q <= rise_s;
         if (!armed) arm_cnt <= arm_cnt + 1'b1;
      end
   end

   always_comb begin
      ev.fall_ev = fall_q & ~fall_s & rise_s;
      ev.rise_ev = ~rise_q & rise_s & ~fall_s;
      fire       = armed & en & (ev.fall_ev | ev.rise_ev);
   end

endmodule

// File: rtl/os_pulse_timer.sv
// Non-retriggerable down-counter that times one pulse.
module os_pulse_timer
   import oneshot_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          fire,
   input  logic [CW-1:0] width,
   output logic          active
);

   tmr_state_e    state;
   logic [CW-1:0] cnt;
   logic [CW-1:0] eff_width;

   assign eff_width = (width == '0) ? CW'(1) : width;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            TMR_IDLE: begin
               if (fire) begin
                  state <= TMR_RUN;
                  cnt   <= eff_width;
               end
            end
            TMR_RUN: begin
               if (cnt == CW'(1)) state <= TMR_IDLE;
               else               cnt   <= cnt - 1'b1;
            end
            default: state <= TMR_IDLE;
         endcase
      end
   end

   assign active = (state == TMR_RUN);

endmodule

// File: rtl/os_channel.sv
// One complete monostable channel.
module os_channel #(
   parameter int CW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_n,
   input  logic          trig_fall,
   input  logic          trig_rise,
   input  logic [CW-1:0] width,
   output logic          q,
   output logic          qn
);

   logic fall_s;
   logic rise_s;
   logic fire;
   logic active;
   logic chan_rst_n;

   assign chan_rst_n = rst_n & clr_n;

   os_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_fall (
      .clk(clk), .rst_n(rst_n), .d(trig_fall), .q(fall_s)
   );

   os_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_rise (
      .clk(clk), .rst_n(rst_n), .d(trig_rise), .q(rise_s)
   );

   os_trig_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate (
      .clk(clk), .rst_n(rst_n), .en(clr_n),
      .fall_s(fall_s), .rise_s(rise_s), .fire(fire)
   );

   os_pulse_timer #(.CW(CW)) i_timer (
      .clk(clk), .arst_n(chan_rst_n), .fire(fire),
      .width(width), .active(active)
   );

   // Clear masks the output directly so it acts without a clock edge
   assign q  = active & clr_n;
   assign qn = ~q;

endmodule

// File: rtl/oneshot_pair.sv
// Top: NCH independent one-shot channels (two by default).
module oneshot_pair #(
   parameter int NCH         = 2,
   parameter int CW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    trig_fall_i,
   input  logic [NCH-1:0]    trig_rise_i,
   input  logic [NCH-1:0]    clr_n_i,
   input  logic [NCH*CW-1:0] width_i,
   output logic [NCH-1:0]    pulse_o,
   output logic [NCH-1:0]    pulse_n_o
);

   if (NCH < 1) begin : g_bad_nch
      $error("oneshot_pair: NCH must be at least 1");
   end
   if (CW < 1) begin : g_bad_cw
      $error("oneshot_pair: CW must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("oneshot_pair: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      os_channel #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) i_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_n    (clr_n_i[i]),
         .trig_fall(trig_fall_i[i]),
         .trig_rise(trig_rise_i[i]),
         .width    (width_i[i*CW +: CW]),
         .q        (pulse_o[i]),
         .qn       (pulse_n_o[i])
      );
   end

endmodule

// File: rtl/oneshot_pair_chk.sv
// Property checker, bound to the top module.
module oneshot_pair_chk #(
   parameter int NCH = 2,
   parameter int CW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NCH-1:0]    trig_fall_i,
   input logic [NCH-1:0]    trig_rise_i,
   input logic [NCH-1:0]    clr_n_i,
   input logic [NCH*CW-1:0] width_i,
   input logic [NCH-1:0]    pulse_o,
   input logic [NCH-1:0]    pulse_n_o
);

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      logic          q_d;
      logic [CW-1:0] w_d;
      logic [CW-1:0] lw;
      logic [CW-1:0] run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_d <= 1'b0;
            w_d <= '0;
            lw  <= '0;
            run <= '0;
         end else begin
            q_d <= pulse_o[i];
            w_d <= width_i[i*CW +: CW];
            if (pulse_o[i] && !q_d) lw <= (w_d == '0) ? CW'(1) : w_d;
            run <= pulse_o[i] ? run + 1'b1 : '0;
         end
      end

      assert_clear_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_n_i[i] |-> (!pulse_o[i] && pulse_n_o[i]));

      assert_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_o[i] != pulse_n_o[i]);

      assert_no_start_from_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pulse_o[i]) |-> ($past(clr_n_i[i]) && clr_n_i[i]));

      assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(pulse_o[i]) && clr_n_i[i] && $past(clr_n_i[i])) |-> (run == lw));

      assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (pulse_o[i] && q_d) |-> (run < lw));
   end

endmodule

bind oneshot_pair oneshot_pair_chk #(.NCH(NCH), .CW(CW)) i_oneshot_pair_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_fall_i(trig_fall_i),
   .trig_rise_i(trig_rise_i),
   .clr_n_i    (clr_n_i),
   .width_i    (width_i),
   .pulse_o    (pulse_o),
   .pulse_n_o  (pulse_n_o)
);

// File: tb/test_oneshot_pair.sv
module test_oneshot_pair;

   localparam int NCH = 2;
   localparam int CW  = 8;

   // Vector fields: [18] channel, [17] 1 = rising-edge trigger,
   // [16] level of the other input, [15:8] width, [7:0] expected cycles
   localparam logic [18:0] VEC [9] = '{
      {1'b0, 1'b0, 1'b1, 8'd5,   8'd5},
      {1'b0, 1'b1, 1'b0, 8'd1,   8'd1},
      {1'b0, 1'b0, 1'b0, 8'd5,   8'd0},
      {1'b0, 1'b1, 1'b1, 8'd5,   8'd0},
      {1'b1, 1'b0, 1'b1, 8'd7,   8'd7},
      {1'b1, 1'b1, 1'b0, 8'd3,   8'd3},
      {1'b1, 1'b0, 1'b0, 8'd4,   8'd0},
      {1'b0, 1'b0, 1'b1, 8'd0,   8'd1},
      {1'b1, 1'b1, 1'b0, 8'd255, 8'd255}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NCH-1:0]    a, b, clr;
   logic [NCH*CW-1:0] wv;
   logic [NCH-1:0]    q, qn;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   oneshot_pair #(.NCH(NCH), .CW(CW)) i_oneshot_pair (
      .clk(clk), .rst_n(rst_n), .trig_fall_i(a), .trig_rise_i(b),
      .clr_n_i(clr), .width_i(wv), .pulse_o(q), .pulse_n_o(qn)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_w(input int ch, input int w);
      wv[ch*CW +: CW] = CW'(w);
   endtask

   // Set idle trigger levels while the channel is held in clear
   task automatic prep(input int ch, input bit kind_b, input bit other);
      clr[ch] = 1'b0;
      cyc(1);
      if (kind_b) begin a[ch] = other; b[ch] = 1'b0; end
      else        begin a[ch] = 1'b1;  b[ch] = other; end
      cyc(4);
      clr[ch] = 1'b1;
      cyc(3);
      chk(q[ch] == 1'b0, "R7 release", q[ch], 0);
   endtask

   task automatic fire(input int ch, input bit kind_b);
      if (kind_b) b[ch] = 1'b1;
      else        a[ch] = 1'b0;
   endtask

   task automatic watch(input int ch, input int len, output int cnt, output int first, output int oth);
      cnt = 0; first = 0; oth = 0;
      for (int i = 1; i <= len; i++) begin
         cyc(1);
         if (q[ch]) begin
            cnt++;
            if (first == 0) first = i;
         end
         if (q[1-ch]) oth++;
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int cnt, first, oth, c0, c1, f0, f1;
      rst_n = 1'b0; a = '1; b = '1; clr = '1; wv = '0;
      cyc(2);
      chk(q == 2'b00,  "R9 reset q",  q,  0);
      chk(qn == 2'b11, "R9 reset qn", qn, 3);
      // trigger-like levels present when reset is released
      a = 2'b00;
      cyc(2);
      rst_n = 1'b1;
      cnt = 0;
      for (int i = 0; i < 12; i++) begin
         cyc(1);
         if (q != 2'b00) cnt++;
      end
      chk(cnt == 0, "R9 no pending", cnt, 0);

      // vector table
      for (int k = 0; k < 9; k++) begin
         logic [18:0] v;
         int ch, w, ex;
         bit kb, ot;
         string tg;
         v  = VEC[k];
         ch = int'(v[18]); kb = v[17]; ot = v[16];
         w  = int'(v[15:8]); ex = int'(v[7:0]);
         tg = (ex == 0) ? "R3" : ((w == 0) ? "R4" : (kb ? "R2" : "R1"));
         prep(ch, kb, ot);
         set_w(ch, w);
         fire(ch, kb);
         watch(ch, w + 8, cnt, first, oth);
         chk(cnt == ex, tg, cnt, ex);
         if (ex > 0) chk(first == 3, tg, first, 3);
         chk(oth == 0, "R10", oth, 0);
         chk(qn == ~q, "R8", qn, ~q);
      end

      // R5 and R4: edges and a width change during a running pulse
      prep(0, 1'b0, 1'b1);
      set_w(0, 10);
      fire(0, 1'b0);
      cnt = 0; first = 0;
      for (int i = 1; i <= 30; i++) begin
         cyc(1);
         if (q[0]) begin
            cnt++;
            if (first == 0) first = i;
         end
         if (i == 4) set_w(0, 2);
         if (i == 5) a[0] = 1'b1;
         if (i == 6) a[0] = 1'b0;
         if (i == 7) b[0] = 1'b0;
         if (i == 8) b[0] = 1'b1;
      end
      chk(cnt == 10, "R5 retrigger", cnt, 10);
      chk(first == 3, "R4 width held", first, 3);

      // R6: clear cuts a pulse at once
      prep(0, 1'b0, 1'b1);
      set_w(0, 20);
      fire(0, 1'b0);
      cnt = 0;
      for (int i = 1; i <= 30; i++) begin
         cyc(1);
         if (q[0]) cnt++;
         if (i == 6) begin
            #2 clr[0] = 1'b0;
            #1;
            chk(q[0] == 1'b0,  "R6 q immediate",  q[0],  0);
            chk(qn[0] == 1'b1, "R6 qn immediate", qn[0], 1);
         end
         if (i == 9) clr[0] = 1'b1;
      end
      chk(cnt == 4, "R6 truncated", cnt, 4);

      // R7: trigger while clear is low
      prep(1, 1'b0, 1'b1);
      set_w(1, 5);
      clr[1] = 1'b0;
      cyc(1);
      fire(1, 1'b0);
      cyc(6);
      clr[1] = 1'b1;
      watch(1, 12, cnt, first, oth);
      chk(cnt == 0, "R7 ignored", cnt, 0);
      chk(oth == 0, "R10", oth, 0);

      // R10: both channels at once with different widths
      prep(0, 1'b0, 1'b1);
      prep(1, 1'b1, 1'b0);
      set_w(0, 4);
      set_w(1, 9);
      fire(0, 1'b0);
      fire(1, 1'b1);
      c0 = 0; c1 = 0; f0 = 0; f1 = 0;
      for (int i = 1; i <= 20; i++) begin
         cyc(1);
         if (q[0]) begin c0++; if (f0 == 0) f0 = i; end
         if (q[1]) begin c1++; if (f1 == 0) f1 = i; end
      end
      chk(c0 == 4, "R10 ch0 length", c0, 4);
      chk(c1 == 9, "R10 ch1 length", c1, 9);
      chk(f0 == 3, "R10 ch0 start",  f0, 3);
      chk(f1 == 3, "R10 ch1 start",  f1, 3);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule